// File: doc/BRIEF.md
# Multi-Slave SPI Master

This block is a serial bus master that moves one byte at a time, in both directions at once, between the host logic and one of several slave devices on a shared bus. The slaves share the serial clock, the outbound data line and the inbound data line. Each slave also has its own active-low select line. A transfer moves eight bits, most significant bit first. One inbound bit is captured for every outbound bit.

The host starts a transfer with a one-cycle strobe. With the strobe it gives the byte to send, the index of the target slave, the two-bit clock mode (idle polarity and sampling phase) and a three-bit divider code. The serial clock comes from dividing the system clock by a power of two between 2 and 256. When the byte is complete, the select line rises again. At the same time the block raises a one-cycle completion pulse, and the received byte is then valid. The mode, divider and slave index are latched when the transfer is accepted. A strobe that arrives while a transfer is running is dropped.

Top module: `spi_multi_master`

## Requirements
- R1: Every serial-clock half period lasts 2^P system cycles, where P is the divider code (0..7), so the serial clock period is 2^(P+1) system cycles (ratios 2 to 256).
- R2: After reset and whenever no transfer runs, every select line is high. During a transfer only select line `slave_sel_i` (bit index equals the latched slave number) is low.
- R3: Each transfer drives the eight bits of `tx_byte_i` on `mosi_o`, bit 7 first and bit 0 last. Each bit is stable at its sampling edge.
- R4: On each of the eight sampling edges one bit of `miso_i` is captured. The first captured bit lands in bit 7 of `rx_byte_o`.
- R5: `mode_i[1]` is the clock polarity: `sck_o` idles at that level when the select falls and again after the byte. A byte contains exactly 16 serial-clock edges.
- R6: `mode_i[0]` is the clock phase. With 0, sampling takes place on edges 1, 3, .., 15 (leaving idle), and bit 7 is on `mosi_o` as soon as the select falls, before any edge. With 1, sampling takes place on edges 2, 4, .., 16 (returning to idle).
- R7: Take the system edge that accepts the start strobe. Exactly 17 half periods after it, the select returns high and `done_o` is high for one cycle with the received byte valid.
- R8: Changes on `mode_i`, `presc_i`, `slave_sel_i` or `tx_byte_i` during a transfer have no effect on that transfer.
- R9: A start strobe raised while a transfer is running is ignored: no second transfer follows and no extra completion pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin a transfer |
| tx_byte_i | input | 8 | Byte to send |
| slave_sel_i | input | 2 | Index of the slave to select |
| mode_i | input | 2 | Bit 1 clock polarity, bit 0 clock phase |
| presc_i | input | 3 | Divider code P; serial clock = system clock / 2^(P+1) |
| rx_byte_o | output | 8 | Byte received in the last transfer |
| done_o | output | 1 | One-cycle pulse at transfer completion |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Outbound serial data |
| miso_i | input | 1 | Inbound serial data |
| cs_n_o | output | 4 | Active-low per-slave select lines |

## Verification
The checker watches rules that hold on every cycle. At most one select is low, and none is low while idle. The serial clock rests at the latched polarity while idle. The outbound line only moves together with a serial-clock edge. The latched configuration stays fixed through a transfer. The completion pulse lasts a single cycle and coincides with the select release. Other behaviour can only be shown by the bench's scenarios, where a model slave on the bus checks it against values worked out independently. This covers the half-period length for each divider code, the edge count, bit order and full-duplex data in all four clock modes, the first-bit placement for phase 0, the completion time, and the rejection of mid-transfer strobes and input changes.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Clock mode as latched at start: polarity in the upper bit.
  typedef struct packed {
    logic cpol;
    logic cpha;
  } spim_mode_t;

  typedef enum logic {
    SPIM_IDLE = 1'b0,
    SPIM_RUN  = 1'b1
  } spim_state_e;

endpackage

// File: rtl/spim_rst_sync.sv
module spim_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int PRESC_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               clear_i,
  input  logic [PRESC_W-1:0] code_i,
  output logic               tick_o
);

  localparam int CNT_W = (1 << PRESC_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             at_limit;

  // Half period is 2^code cycles: limit has 'code' low ones.
  assign limit    = ~({CNT_W{1'b1}} << code_i);
  assign at_limit = (cnt_q == limit);
  assign tick_o   = run_i && at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)       cnt_d = '0;
    else if (run_i) begin
      if (at_limit)    cnt_d = '0;
      else             cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              commit_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);

  logic [DATA_W-1:0] txsr_q, txsr_d;
  logic [DATA_W-1:0] rxsr_q, rxsr_d;
  logic [DATA_W-1:0] rxout_q, rxout_d;

  always_comb begin
    txsr_d = txsr_q;
    if (load_i)       txsr_d = tx_i;
    else if (shift_i) txsr_d = {txsr_q[DATA_W-2:0], 1'b0};
  end

  always_comb begin
    rxsr_d = rxsr_q;
    if (sample_i) rxsr_d = {rxsr_q[DATA_W-2:0], miso_i};
  end

  always_comb begin
    rxout_d = rxout_q;
    if (commit_i) rxout_d = rxsr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsr_q  <= '0;
      rxsr_q  <= '0;
      rxout_q <= '0;
    end else begin
      txsr_q  <= txsr_d;
      rxsr_q  <= rxsr_d;
      rxout_q <= rxout_d;
    end
  end

  assign mosi_o = txsr_q[DATA_W-1];
  assign rx_o   = rxout_q;

endmodule

// File: rtl/spim_select.sv
module spim_select #(
  parameter int NUM_SLAVES = 4,
  parameter int SEL_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  logic [SEL_W-1:0]      idx_i,
  output logic [NUM_SLAVES-1:0] cs_n_o
);

  logic [NUM_SLAVES-1:0] cs_n_d, cs_n_q;

  for (genvar gi = 0; gi < NUM_SLAVES; gi++) begin : g_line
    assign cs_n_d[gi] = !(en_i && (idx_i == SEL_W'(gi)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n_q <= '1;
    else        cs_n_q <= cs_n_d;
  end

  assign cs_n_o = cs_n_q;

endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master #(
  parameter int NUM_SLAVES = 4,
  parameter int DATA_W     = 8,
  parameter int PRESC_W    = 3,
  parameter int SEL_W      = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [DATA_W-1:0]     tx_byte_i,
  input  logic [SEL_W-1:0]      slave_sel_i,
  input  logic [1:0]            mode_i,
  input  logic [PRESC_W-1:0]    presc_i,
  output logic [DATA_W-1:0]     rx_byte_o,
  output logic                  done_o,
  output logic                  sck_o,
  output logic                  mosi_o,
  input  logic                  miso_i,
  output logic [NUM_SLAVES-1:0] cs_n_o
);

  import spim_pkg::*;

  localparam int NUM_EDGES = 2 * DATA_W;
  localparam int EDGE_W    = $clog2(NUM_EDGES + 1);

  logic rst_n_s;

  spim_state_e        state_q, state_d;
  spim_mode_t         mode_q, mode_d;
  logic [PRESC_W-1:0] presc_q, presc_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [EDGE_W-1:0]  edge_q, edge_d;
  logic               sck_q, sck_d;
  logic               done_q, done_d;

  logic accept, running, tick;
  logic toggle, finish, leading, sample_edge, shift_edge;

  spim_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign running = (state_q == SPIM_RUN);
  assign accept  = start_i && !running;

  spim_clkdiv #(.PRESC_W(PRESC_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run_i   (running),
    .clear_i (accept),
    .code_i  (presc_q),
    .tick_o  (tick)
  );

  // Edge k = edge_q + 1; odd k leaves idle.
  assign leading     = ~edge_q[0];
  assign toggle      = tick && (edge_q < EDGE_W'(NUM_EDGES));
  assign finish      = tick && (edge_q == EDGE_W'(NUM_EDGES));
  assign sample_edge = toggle && (leading ^ mode_q.cpha);
  assign shift_edge  = toggle && !(leading ^ mode_q.cpha)
                       && (edge_q != '0)
                       && (edge_q != EDGE_W'(NUM_EDGES - 1));

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    presc_d = presc_q;
    sel_d   = sel_q;
    edge_d  = edge_q;
    sck_d   = sck_q;
    done_d  = 1'b0;
    if (accept) begin
      state_d = SPIM_RUN;
      mode_d  = spim_mode_t'(mode_i);
      presc_d = presc_i;
      sel_d   = slave_sel_i;
      edge_d  = '0;
      sck_d   = mode_i[1];
    end else if (running) begin
      if (toggle) begin
        sck_d  = ~sck_q;
        edge_d = edge_q + 1'b1;
      end
      if (finish) begin
        state_d = SPIM_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= SPIM_IDLE;
      mode_q  <= '0;
      presc_q <= '0;
      sel_q   <= '0;
      edge_q  <= '0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      presc_q <= presc_d;
      sel_q   <= sel_d;
      edge_q  <= edge_d;
      sck_q   <= sck_d;
      done_q  <= done_d;
    end
  end

  spim_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (accept),
    .tx_i     (tx_byte_i),
    .sample_i (sample_edge),
    .shift_i  (shift_edge),
    .commit_i (finish),
    .miso_i   (miso_i),
    .mosi_o   (mosi_o),
    .rx_o     (rx_byte_o)
  );

  spim_select #(.NUM_SLAVES(NUM_SLAVES), .SEL_W(SEL_W)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .en_i   (state_d == SPIM_RUN),
    .idx_i  (sel_d),
    .cs_n_o (cs_n_o)
  );

  assign sck_o  = sck_q;
  assign done_o = done_q;

endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int NUM_SLAVES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic [1:0]            cfg,
  input logic                  cpol,
  input logic                  sck,
  input logic                  mosi,
  input logic                  done,
  input logic [NUM_SLAVES-1:0] cs_n
);

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));

  a_r5_sck_rest: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));

  a_r3_mosi_with_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(sck)) |-> $stable(mosi));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((&cs_n) && !$past(&cs_n)));

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg));

endmodule

bind spi_multi_master spim_checker #(.NUM_SLAVES(NUM_SLAVES)) u_chk (
  .clk  (clk),
  .rst_n(rst_n_s),
  .busy (state_q == spim_pkg::SPIM_RUN),
  .cfg  (mode_q),
  .cpol (mode_q.cpol),
  .sck  (sck_o),
  .mosi (mosi_o),
  .done (done_o),
  .cs_n (cs_n_o)
);

// File: tb/spi_multi_master_test.sv
module spi_multi_master_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] tx_byte_i = '0;
  logic [1:0] slave_sel_i = '0;
  logic [1:0] mode_i = '0;
  logic [2:0] presc_i = '0;
  logic [7:0] rx_byte_o;
  logic       done_o, sck_o, mosi_o;
  logic       miso_i = 1'b0;
  logic [3:0] cs_n_o;

  always #4 clk = ~clk;

  spi_multi_master uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_byte_i(tx_byte_i),
    .slave_sel_i(slave_sel_i), .mode_i(mode_i), .presc_i(presc_i),
    .rx_byte_o(rx_byte_o), .done_o(done_o), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit ended = 0;

  // expectations of the current transfer
  int         c0, half, edges, last_cyc, intv_bad, m_idx;
  logic       e_cpol, e_cpha;
  logic [7:0] e_tx, e_pat, mosi_cap;
  logic [1:0] e_slave;
  logic       prev_sck = 1'b0, prev_act = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    ended = 1;
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!ended && cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  // Model slave and bus observer, sampled away from the active edge.
  always @(negedge clk) begin
    logic act;
    act = (cs_n_o != 4'hF);
    if (act && !prev_act) begin
      edges = 0; last_cyc = c0; m_idx = 7; mosi_cap = '0;
      miso_i = e_pat[7];
      chk(cs_n_o == ~(4'b1 << e_slave), "R2 select", cs_n_o, ~(4'b1 << e_slave) & 4'hF);
      chk(sck_o == e_cpol, "R5 sck idle at select", sck_o, e_cpol);
      if (!e_cpha) chk(mosi_o == e_tx[7], "R6 first bit before edge", mosi_o, e_tx[7]);
    end else if (act && prev_act && sck_o != prev_sck) begin
      edges++;
      if (cyc - last_cyc != half) intv_bad++;
      last_cyc = cyc;
      if ((edges % 2 == 1) ^ e_cpha) mosi_cap = {mosi_cap[6:0], mosi_o};
      else if (edges != 1 && edges != 16) begin
        m_idx--;
        miso_i = e_pat[m_idx];
      end
    end
    prev_act = act;
    prev_sck = sck_o;
  end

  task automatic xfer(input int m, input int p, input int s,
                      input logic [7:0] tx, input logic [7:0] pt, input bit disturb);
    int n;
    bit quiet;
    @(negedge clk);
    e_cpol = m[1]; e_cpha = m[0]; e_tx = tx; e_pat = pt; e_slave = 2'(s);
    half = 1 << p; intv_bad = 0; c0 = cyc + 1;
    mode_i = 2'(m); presc_i = 3'(p); slave_sel_i = 2'(s); tx_byte_i = tx;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      // R8 / R9: change every input and strobe start mid-transfer
      repeat (5 * half) @(negedge clk);
      mode_i = ~mode_i; presc_i = presc_i ^ 3'd7;
      slave_sel_i = slave_sel_i + 2'd1; tx_byte_i = ~tx_byte_i;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(cyc == c0 + 17 * half, "R7 completion time", cyc - c0, 17 * half);
    chk(cs_n_o == 4'hF, "R7 select released", cs_n_o, 15);
    chk(edges == 16, "R5 edge count", edges, 16);
    chk(sck_o == e_cpol, "R5 sck idle after", sck_o, e_cpol);
    chk(intv_bad == 0, "R1 half period", intv_bad, 0);
    chk(mosi_cap == tx, "R3 mosi bits", mosi_cap, tx);
    chk(rx_byte_o == pt, "R4 rx byte", rx_byte_o, pt);
    if (disturb) chk(1'b1, "R8 (checked above)", 0, 0);
    @(negedge clk);
    chk(!done_o, "R7 done one cycle", done_o, 0);
    if (disturb) begin
      quiet = 1;
      repeat (3 * half + 8) begin
        @(negedge clk);
        if (done_o || cs_n_o != 4'hF) quiet = 0;
      end
      chk(quiet, "R9 no second transfer", quiet, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n_o == 4'hF, "R2 reset selects", cs_n_o, 15);
    chk(sck_o == 1'b0, "R5 reset sck", sck_o, 0);
    chk(done_o == 1'b0, "R7 reset done", done_o, 0);

    // every mode against every divider code
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 8; p++)
        xfer(m, p, (m + p) % 4, 8'(8'h3C + 37 * p + 11 * m), 8'(8'hC5 ^ (29 * p + m)), 1'b0);

    // data patterns at the fastest divider, all modes and slaves
    for (int m = 0; m < 4; m++)
      for (int v = 0; v < 16; v++)
        xfer(m, 0, v % 4, 8'(v * 17), 8'(~(v * 13 + m)), 1'b0);

    // mid-transfer disturbance: latched config and busy start rejection
    for (int m = 0; m < 4; m++)
      xfer(m, 2 + (m % 2), 3 - m, 8'h96, 8'h5A, 1'b1);

    summary();
  end

endmodule